// File: doc/BRIEF.md
# Parallelism-Aware Request Priority Selector

This block sits in front of one flash chip and looks at up to eight pending memory requests waiting for it. Each request slot carries a die bit, a plane bit, a page offset, the identifier of the host I/O it belongs to, and a read/write flag. The block decides which subset of those requests should be committed together as one transaction. The subset may interleave both dies and use both planes of a die at once. It returns that subset as a bit mask over the slots.

Every legal group gets a score. The primary key is how many distinct die/plane positions the group fills. The secondary key is the largest number of members that come from the same host I/O. Any remaining tie goes to the group holding the lowest slot index. A write is held back while an older read to the same die and plane is still waiting, so the read is served first. A grant is produced only from a cycle in which the chip signals ready. The surrounding controller removes granted slots and sequences the flash commands.

Top module: `prs_sel`

## Requirements
- R1: While rst_ni is low, grant_valid_o, grant_mask_o, grant_depth_o and grant_conn_o are all zero.
- R2: Outputs are registered. After a rising edge where ready_i was 1 and at least one slot is eligible, grant_valid_o is 1 and the grant describes the inputs seen at that edge. After an edge with ready_i at 0, all grant outputs are zero.
- R3: A granted group holds at most one slot per (die, plane) position. Two granted slots on the same die have different plane bits and equal page offsets. Every granted slot is eligible.
- R4: grant_depth_o equals the number of set bits in grant_mask_o. No legal group has a larger count.
- R5: grant_conn_o is the largest number of granted slots sharing one req_io_i value. Among legal groups of maximal depth, none has a larger such count.
- R6: When depth and connectivity both tie, the grant is the group that contains the lowest slot index at which the tied groups differ.
- R7: Slot index gives age, and a lower index is older. A write (req_write_i bit = 1) in slot j is not eligible while some slot i < j holds a valid read (bit = 0) with the same die bit and plane bit.
- R8: Slots on die 0 (req_die_i = 0) and die 1 (req_die_i = 1) may be granted together whatever their page offsets.
- R9: Invalid slots are never granted. With no eligible slot, grant_valid_o is 0 and the mask is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ready_i | input | 1 | Chip ready/busy line, 1 = ready |
| req_valid_i | input | N_SLOTS | Slot holds a pending request |
| req_write_i | input | N_SLOTS | 1 = write, 0 = read |
| req_die_i | input | N_SLOTS | Target die bit per slot |
| req_plane_i | input | N_SLOTS | Target plane bit per slot |
| req_page_i | input | N_SLOTS*PAGE_W | Page offset per slot, slot s at bits [s*PAGE_W +: PAGE_W] |
| req_io_i | input | N_SLOTS*IO_W | Host I/O identifier per slot, slot s at bits [s*IO_W +: IO_W] |
| grant_valid_o | output | 1 | A group was chosen |
| grant_mask_o | output | N_SLOTS | Chosen slots |
| grant_depth_o | output | 3 | Number of chosen slots |
| grant_conn_o | output | 3 | Largest same-I/O count within the group |

## Verification
Directed sets fill all four positions with matched or mismatched pages on a die. They show whether a multi-plane pair is accepted only when the pages agree, and whether cross-die interleave ignores pages. A connectivity case makes two depth-2 groups tie on depth so that only the same-I/O count separates them. A plain tie case then exposes the lowest-slot rule. A read/write pair on one plane shows that the hold-back changes which group wins. Constrained random slots use narrow page and identifier ranges so that pairs and ties are frequent, with ready dropped at random. Every grant is compared against an exhaustive search over all slot subsets.

// File: rtl/prs_pkg.sv
package prs_pkg;
  localparam int DIES  = 2;
  localparam int CNT_W = 3;

  // options per die: empty, every single slot, every slot pair
  function automatic int opt_count(int n);
    return n * (n + 1) / 2 + 1;
  endfunction

  function automatic int opt_index(int n, int i, int j);
    return 1 + i * n - (i * (i - 1)) / 2 + (j - i);
  endfunction
endpackage

// File: rtl/prs_hazard.sv
module prs_hazard #(
  parameter int N = 8
) (
  input  logic [N-1:0] valid_i,
  input  logic [N-1:0] write_i,
  input  logic [N-1:0] die_i,
  input  logic [N-1:0] plane_i,
  output logic [N-1:0] elig_o
);
  logic [N-1:0] older_rd;

  always_comb begin
    older_rd = '0;
    for (int j = 1; j < N; j++) begin
      for (int i = 0; i < j; i++) begin
        if (valid_i[i] && !write_i[i] && die_i[i] == die_i[j] && plane_i[i] == plane_i[j])
          older_rd[j] = 1'b1;
      end
    end
    elig_o = valid_i & ~(write_i & older_rd);
  end
endmodule

// File: rtl/prs_die_opts.sv
module prs_die_opts #(
  parameter int N      = 8,
  parameter int PAGE_W = 8,
  parameter int N_OPT  = 37,
  parameter bit DIE_ID = 1'b0
) (
  input  logic [N-1:0]        elig_i,
  input  logic [N-1:0]        die_i,
  input  logic [N-1:0]        plane_i,
  input  logic [N*PAGE_W-1:0] page_i,
  output logic [N-1:0]        opt_mask_o [N_OPT],
  output logic [N_OPT-1:0]    opt_ok_o,
  output logic [1:0]          opt_size_o [N_OPT]
);
  localparam logic [N-1:0] ONE = N'(1);

  assign opt_mask_o[0] = '0;
  assign opt_ok_o[0]   = 1'b1;
  assign opt_size_o[0] = 2'd0;

  for (genvar gi = 0; gi < N; gi++) begin : g_i
    for (genvar gj = gi; gj < N; gj++) begin : g_j
      localparam int K = prs_pkg::opt_index(N, gi, gj);
      if (gi == gj) begin : g_single
        assign opt_mask_o[K] = ONE << gi;
        assign opt_ok_o[K]   = elig_i[gi] && (die_i[gi] == DIE_ID);
        assign opt_size_o[K] = 2'd1;
      end else begin : g_pair
        // multi-plane pair: same die, other plane, same page
        assign opt_mask_o[K] = (ONE << gi) | (ONE << gj);
        assign opt_ok_o[K]   = elig_i[gi] && elig_i[gj]
                             && (die_i[gi] == DIE_ID) && (die_i[gj] == DIE_ID)
                             && (plane_i[gi] != plane_i[gj])
                             && (page_i[gi*PAGE_W +: PAGE_W] == page_i[gj*PAGE_W +: PAGE_W]);
        assign opt_size_o[K] = 2'd2;
      end
    end
  end
endmodule

// File: rtl/prs_pick.sv
module prs_pick #(
  parameter int N     = 8,
  parameter int IO_W  = 4,
  parameter int N_OPT = 37
) (
  input  logic [N-1:0]      m0_i [N_OPT],
  input  logic [N_OPT-1:0]  ok0_i,
  input  logic [1:0]        sz0_i [N_OPT],
  input  logic [N-1:0]      m1_i [N_OPT],
  input  logic [N_OPT-1:0]  ok1_i,
  input  logic [1:0]        sz1_i [N_OPT],
  input  logic [N*IO_W-1:0] io_i,
  output logic              found_o,
  output logic [N-1:0]      mask_o,
  output logic [prs_pkg::CNT_W-1:0] depth_o,
  output logic [prs_pkg::CNT_W-1:0] conn_o
);
  localparam int CW    = prs_pkg::CNT_W;
  localparam int KEY_W = 2 * CW + N;

  logic [N-1:0]     same_io [N];
  logic [N-1:0]     cand, rev;
  logic [CW-1:0]    dep, con, cnt;
  logic [KEY_W-1:0] key, best_key;

  always_comb begin
    for (int p = 0; p < N; p++)
      for (int q = 0; q < N; q++)
        same_io[p][q] = (io_i[p*IO_W +: IO_W] == io_i[q*IO_W +: IO_W]);
  end

  // key = {depth, connectivity, slot order}; bit-reversed mask favours low slots
  always_comb begin
    best_key = '0;
    mask_o   = '0;
    depth_o  = '0;
    conn_o   = '0;
    cand = '0; rev = '0; dep = '0; con = '0; cnt = '0; key = '0;
    for (int a = 0; a < N_OPT; a++) begin
      for (int b = 0; b < N_OPT; b++) begin
        cand = m0_i[a] | m1_i[b];
        dep  = CW'(sz0_i[a]) + CW'(sz1_i[b]);
        con  = '0;
        for (int p = 0; p < N; p++) begin
          cnt = CW'($countones(cand & same_io[p]));
          if (cand[p] && cnt > con) con = cnt;
          rev[N-1-p] = cand[p];
        end
        key = {dep, con, rev};
        if (ok0_i[a] && ok1_i[b] && key > best_key) begin
          best_key = key;
          mask_o   = cand;
          depth_o  = dep;
          conn_o   = con;
        end
      end
    end
    found_o = (best_key != '0);
  end
endmodule

// File: rtl/prs_sel.sv
module prs_sel #(
  parameter int N_SLOTS = 8,
  parameter int PAGE_W  = 8,
  parameter int IO_W    = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      ready_i,
  input  logic [N_SLOTS-1:0]        req_valid_i,
  input  logic [N_SLOTS-1:0]        req_write_i,
  input  logic [N_SLOTS-1:0]        req_die_i,
  input  logic [N_SLOTS-1:0]        req_plane_i,
  input  logic [N_SLOTS*PAGE_W-1:0] req_page_i,
  input  logic [N_SLOTS*IO_W-1:0]   req_io_i,
  output logic                      grant_valid_o,
  output logic [N_SLOTS-1:0]        grant_mask_o,
  output logic [2:0]                grant_depth_o,
  output logic [2:0]                grant_conn_o
);
  localparam int N_OPT = prs_pkg::opt_count(N_SLOTS);
  localparam int CW    = prs_pkg::CNT_W;

  logic [N_SLOTS-1:0] elig;
  logic [N_SLOTS-1:0] opt_mask [prs_pkg::DIES][N_OPT];
  logic [N_OPT-1:0]   opt_ok   [prs_pkg::DIES];
  logic [1:0]         opt_size [prs_pkg::DIES][N_OPT];
  logic               sel_found;
  logic [N_SLOTS-1:0] sel_mask;
  logic [CW-1:0]      sel_depth, sel_conn;

  prs_hazard #(.N(N_SLOTS)) u_hazard (
    .valid_i (req_valid_i),
    .write_i (req_write_i),
    .die_i   (req_die_i),
    .plane_i (req_plane_i),
    .elig_o  (elig)
  );

  for (genvar gd = 0; gd < prs_pkg::DIES; gd++) begin : g_die
    prs_die_opts #(
      .N(N_SLOTS), .PAGE_W(PAGE_W), .N_OPT(N_OPT), .DIE_ID(gd == 1)
    ) u_opts (
      .elig_i     (elig),
      .die_i      (req_die_i),
      .plane_i    (req_plane_i),
      .page_i     (req_page_i),
      .opt_mask_o (opt_mask[gd]),
      .opt_ok_o   (opt_ok[gd]),
      .opt_size_o (opt_size[gd])
    );
  end

  prs_pick #(.N(N_SLOTS), .IO_W(IO_W), .N_OPT(N_OPT)) u_pick (
    .m0_i    (opt_mask[0]),
    .ok0_i   (opt_ok[0]),
    .sz0_i   (opt_size[0]),
    .m1_i    (opt_mask[1]),
    .ok1_i   (opt_ok[1]),
    .sz1_i   (opt_size[1]),
    .io_i    (req_io_i),
    .found_o (sel_found),
    .mask_o  (sel_mask),
    .depth_o (sel_depth),
    .conn_o  (sel_conn)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grant_valid_o <= 1'b0;
      grant_mask_o  <= '0;
      grant_depth_o <= '0;
      grant_conn_o  <= '0;
    end else if (ready_i && sel_found) begin
      grant_valid_o <= 1'b1;
      grant_mask_o  <= sel_mask;
      grant_depth_o <= sel_depth;
      grant_conn_o  <= sel_conn;
    end else begin
      grant_valid_o <= 1'b0;
      grant_mask_o  <= '0;
      grant_depth_o <= '0;
      grant_conn_o  <= '0;
    end
  end

  // R2
  ready_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_valid_o |-> $past(ready_i));

  // R2
  grant_issue_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(ready_i) && $past(|elig)) |-> grant_valid_o);

  // R3
  elig_subset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_valid_o |-> ((grant_mask_o & ~$past(elig)) == '0));

  // R4
  depth_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(grant_mask_o) == int'(grant_depth_o));

  // R5
  conn_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_valid_o |-> (grant_conn_o != '0 && grant_conn_o <= grant_depth_o));

  // R9
  idle_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !grant_valid_o |-> (grant_mask_o == '0 && grant_conn_o == '0));
endmodule

// File: tb/prs_sel_bench.sv
`timescale 1ns/1ps
module prs_sel_bench;
  localparam int N  = 8;
  localparam int PW = 8;
  localparam int IW = 4;

  logic clk = 1'b0, rst_n = 1'b0, ready = 1'b0;
  logic [N-1:0] v, w, d, p;
  logic [N*PW-1:0] pg;
  logic [N*IW-1:0] io;
  logic gv;
  logic [N-1:0] gm;
  logic [2:0] gdep, gcon;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  prs_sel #(.N_SLOTS(N), .PAGE_W(PW), .IO_W(IW)) u_prs_sel (
    .clk_i(clk), .rst_ni(rst_n), .ready_i(ready),
    .req_valid_i(v), .req_write_i(w), .req_die_i(d), .req_plane_i(p),
    .req_page_i(pg), .req_io_i(io),
    .grant_valid_o(gv), .grant_mask_o(gm), .grant_depth_o(gdep), .grant_conn_o(gcon)
  );

  always #5 clk = ~clk;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clear_all();
    v = '0; w = '0; d = '0; p = '0; pg = '0; io = '0;
  endtask

  task automatic put(int s, bit wr, bit di, bit pl, int page, int ioid);
    v[s] = 1'b1; w[s] = wr; d[s] = di; p[s] = pl;
    pg[s*PW +: PW] = PW'(page);
    io[s*IW +: IW] = IW'(ioid);
  endtask

  // R7: write held while an older read waits on the same die and plane
  function automatic logic [N-1:0] model_elig();
    logic [N-1:0] e = v;
    for (int j = 0; j < N; j++)
      for (int i = 0; i < j; i++)
        if (w[j] && v[i] && !w[i] && d[i] == d[j] && p[i] == p[j]) e[j] = 1'b0;
    return e;
  endfunction

  // exhaustive search over all slot subsets
  task automatic model(output bit f, output logic [N-1:0] m, output int dep, output int con);
    logic [N-1:0] e = model_elig();
    int best = 0;
    f = 1'b0; m = '0; dep = 0; con = 0;
    for (int s = 1; s < (1 << N); s++) begin
      bit legal = 1'b1;
      bit seen [2][2];
      int dpg [2];
      bit dhas [2];
      int cd = 0, cc = 0, rv = 0, key;
      foreach (seen[a, b]) seen[a][b] = 1'b0;
      dhas[0] = 1'b0; dhas[1] = 1'b0; dpg[0] = 0; dpg[1] = 0;
      for (int k = 0; k < N; k++) begin
        if (s[k]) begin
          if (!e[k]) legal = 1'b0;
          if (seen[d[k]][p[k]]) legal = 1'b0;
          seen[d[k]][p[k]] = 1'b1;
          if (dhas[d[k]] && dpg[d[k]] != int'(pg[k*PW +: PW])) legal = 1'b0;
          dhas[d[k]] = 1'b1;
          dpg[d[k]] = int'(pg[k*PW +: PW]);
          cd++;
          rv |= 1 << (N - 1 - k);
        end
      end
      if (legal) begin
        for (int k = 0; k < N; k++) begin
          int c = 0;
          if (s[k]) begin
            for (int q = 0; q < N; q++)
              if (s[q] && io[q*IW +: IW] == io[k*IW +: IW]) c++;
            if (c > cc) cc = c;
          end
        end
        key = (cd << (N + 3)) | (cc << N) | rv;
        if (key > best) begin
          best = key; f = 1'b1; m = N'(s); dep = cd; con = cc;
        end
      end
    end
  endtask

  task automatic step(string req);
    bit f; logic [N-1:0] m; int dep, con;
    model(f, m, dep, con);
    if (!ready) begin f = 1'b0; m = '0; dep = 0; con = 0; end
    @(posedge clk);
    @(negedge clk);
    chk(req, "valid", int'(gv), int'(f));
    chk(req, "mask", int'(gm), int'(m));
    chk(req, "depth", int'(gdep), dep);
    chk(req, "conn", int'(gcon), con);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL R2 watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    clear_all();
    ready = 1'b0;
    repeat (3) @(negedge clk);
    // R1
    chk("R1", "valid", int'(gv), 0);
    chk("R1", "mask", int'(gm), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R9: nothing pending
    ready = 1'b1; clear_all(); step("R9");

    // R2: ready low with pending work
    put(0, 0, 0, 0, 1, 1); ready = 1'b0; step("R2");
    ready = 1'b1; step("R2");

    // R4 R8: all four positions, die pages differ
    clear_all();
    put(0, 0, 0, 0, 3, 1); put(1, 0, 0, 1, 3, 2);
    put(2, 0, 1, 0, 9, 3); put(3, 0, 1, 1, 9, 4);
    step("R4 R8");
    // expect mask 0x0f depth 4
    chk("R4", "mask direct", int'(gm), 8'h0f);

    // R8: cross die with different pages
    clear_all();
    put(0, 0, 0, 0, 1, 1); put(1, 0, 1, 0, 5, 2); put(2, 0, 1, 1, 5, 3);
    step("R8");
    chk("R8", "mask direct", int'(gm), 8'h07);

    // R3: same die, planes differ, pages differ -> no pair
    clear_all();
    put(0, 0, 0, 0, 1, 1); put(1, 0, 0, 1, 2, 1);
    step("R3");
    chk("R3", "depth direct", int'(gdep), 1);

    // R5: connectivity breaks the depth tie
    clear_all();
    put(0, 0, 0, 0, 0, 1); put(1, 0, 0, 0, 0, 2); put(2, 0, 1, 0, 0, 2);
    step("R5");
    chk("R5", "mask direct", int'(gm), 8'h06);

    // R6: full tie -> lowest slot
    clear_all();
    put(0, 0, 0, 0, 0, 1); put(1, 0, 0, 0, 0, 2);
    step("R6");
    chk("R6", "mask direct", int'(gm), 8'h01);

    // R7: held write changes the winner
    clear_all();
    put(0, 0, 0, 0, 0, 1); put(3, 1, 0, 0, 0, 6); put(4, 0, 1, 0, 0, 6);
    step("R7");
    chk("R7", "mask direct", int'(gm), 8'h11);

    // R7: older write is not held by a younger read
    clear_all();
    put(0, 1, 1, 1, 0, 1); put(1, 0, 1, 1, 0, 2);
    step("R7");
    chk("R7", "mask direct", int'(gm), 8'h01);

    // random: R3 R4 R5 R6 R7 R9
    for (int it = 0; it < 400; it++) begin
      clear_all();
      for (int s = 0; s < N; s++)
        if ($urandom % 4 != 0)
          put(s, ($urandom % 3) == 0, 1'($urandom % 2), 1'($urandom % 2),
              int'($urandom % 2), int'($urandom % 4));
      ready = ($urandom % 5) != 0;
      step("R3 R4 R5 R6 R7 random");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule